// File: doc/BRIEF.md
# Software Generated Interrupt Dispatcher

This block takes a 64-bit request word for a software-generated interrupt (SGI) from one processor, along with that processor's index. It works out which processors should receive the interrupt. For each of them it raises a one-cycle pending-set strobe, and the downstream pending storage latches the requested interrupt ID from that strobe. A kick pulse tells the wake-up logic that at least one processor was signalled. A done pulse marks the end of every request.

Each processor's affinity (levels 0 to 3, one byte each) is fixed by a parameter table. The dispatcher examines one processor per clock, in ascending index order. It holds a busy flag while scanning and takes no new request until the scan is over.

In targeted mode, a processor is selected when its three upper affinity levels equal those in the request and the target-list bit indexed by its level-0 affinity is set. That bit is then removed from a working copy of the list. The scan stops as soon as the working copy is empty.

In broadcast mode, every processor except the requester is selected.

Top module: `sgi_dispatch`

## Requirements
- R1: Request word fields: target list in bits [15:0], affinity level 1 in [23:16], interrupt ID in [27:24], affinity level 2 in [39:32], routing-mode bit at 40 (1 = broadcast), affinity level 3 in [55:48]. `pend_id_o` carries the interrupt ID of the request accepted last.
- R2: A request is accepted only on a clock edge where `req_valid_i` is high and `busy_o` is low. A request presented while `busy_o` is high is ignored and does not change the scan in progress.
- R3: A request that starts a scan is accepted at edge E0. Processor k is examined at edge E(k+1), and its strobe is visible after that edge. `pend_set_o` never has more than one bit set.
- R4: In broadcast mode, every processor other than `req_src_i` receives a strobe, and the scan covers all processors.
- R5: In targeted mode, processor k is selected only if its levels 1 to 3 equal the request's levels and its level-0 value is below 16 with the indexed target-list bit still set in the working list.
- R6: In targeted mode, a selected processor's level-0 bit is cleared from the working list. When the list becomes empty, `done_o` pulses in the same cycle as that processor's strobe and the scan ends. Otherwise `done_o` pulses with the examination of the last processor.
- R7: `kick_o` pulses together with `done_o` if and only if at least one processor was strobed for that request.
- R8: A targeted request with an all-zero target list is completed at acceptance. `done_o` is visible after E0, `busy_o` never rises, and no strobe or kick is produced.
- R9: After reset, `busy_o`, `pend_set_o`, `done_o` and `kick_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_word_i | input | 64 | SGI request word |
| req_src_i | input | IDXW | Index of the requesting processor |
| busy_o | output | 1 | Scan in progress |
| pend_set_o | output | NUM_PE | Per-processor pending-set strobe |
| pend_id_o | output | 4 | Interrupt ID that goes with the strobes |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| kick_o | output | 1 | Wake-up pulse, at least one target signalled |

## Verification
Three events can land in the same cycle in targeted mode: the strobe of the processor that empties the working list, the done pulse that ends the scan early, and the kick. Single-target requests and random lists whose last set bit points at a mid-table processor provoke this. Each sampled cycle is compared against a bench model of strobe, done and kick.

A second request pushed in while the scan is running overlaps the scan itself. It is judged by checking that the strobe sequence, the done position and the reported ID all match the first request alone.

// File: rtl/sgi_disp_pkg.sv
// Shared field positions and the decoded request type for the SGI dispatcher.
// Assumes the 64-bit request word layout listed in the brief (R1).
package sgi_disp_pkg;

    localparam int LIST_W = 16;
    localparam int ID_W   = 4;
    localparam int BCAST_BIT = 40;

    typedef struct packed {
        logic [ID_W-1:0]   intid;
        logic [LIST_W-1:0] tlist;
        logic [23:0]       aff_hi;   // {level3, level2, level1}
        logic              bcast;
    } sgi_req_t;

    // Pull the request fields out of the raw word.
    function automatic sgi_req_t decode_req(input logic [63:0] w);
        sgi_req_t r;
        r.intid  = w[27:24];
        r.tlist  = w[15:0];
        r.aff_hi = {w[55:48], w[39:32], w[23:16]};
        r.bcast  = w[BCAST_BIT];
        return r;
    endfunction

endpackage

// File: rtl/sgi_pe_match.sv
// Target matcher: decides whether the processor at the scan index is a target
// and which target-list bit it consumes. Per-processor logic is generated from
// the affinity table; the table entry layout is {aff3, aff2, aff1, aff0}.
module sgi_pe_match #(
    parameter int NUM_PE = 4,
    parameter logic [NUM_PE*32-1:0] PE_AFF = '0,
    parameter int IDXW = 2
) (
    input  logic [IDXW-1:0] idx_i,
    input  logic [IDXW-1:0] src_i,
    input  logic            bcast_i,
    input  logic [23:0]     aff_hi_i,
    input  logic [15:0]     list_i,
    output logic            hit_o,
    output logic [15:0]     clr_o
);
    logic [NUM_PE-1:0]       hit_vec;
    logic [NUM_PE-1:0][15:0] clr_vec;

    for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
        localparam logic [31:0] ENT   = PE_AFF[32*k +: 32];
        localparam logic [7:0]  AFF0  = ENT[7:0];
        localparam bit          A0_OK = (AFF0 < 8'd16);
        logic lvl_ok;
        logic in_list;
        // Upper affinity levels must match exactly.
        assign lvl_ok  = (aff_hi_i == ENT[31:8]);
        // Level-0 value must address an existing, still-set list bit.
        assign in_list = A0_OK ? list_i[AFF0[3:0]] : 1'b0;
        // Selection rule per routing mode.
        assign hit_vec[k] = bcast_i ? (src_i != IDXW'(k)) : (lvl_ok && in_list);
        // Bit removed from the working list when this processor is taken.
        assign clr_vec[k] = (!bcast_i && A0_OK) ? (16'd1 << AFF0[3:0]) : 16'd0;
    end

    // Select the result for the current scan position.
    always_comb begin
        hit_o = 1'b0;
        clr_o = 16'd0;
        if (int'(idx_i) < NUM_PE) begin
            hit_o = hit_vec[idx_i];
            clr_o = hit_vec[idx_i] ? clr_vec[idx_i] : 16'd0;
        end
    end
endmodule

// File: rtl/sgi_scan_ctrl.sv
// Scan controller: accepts a request when idle, walks processors one per
// clock, drives registered strobes, done and kick. Assumes the matcher is
// combinational on the current index and working list.
module sgi_scan_ctrl
    import sgi_disp_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int IDXW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  sgi_req_t          req_i,
    input  logic [IDXW-1:0]   req_src_i,
    input  logic              hit_i,
    input  logic [15:0]       clr_i,
    output logic [IDXW-1:0]   idx_o,
    output logic [IDXW-1:0]   src_o,
    output logic              bcast_o,
    output logic [23:0]       aff_hi_o,
    output logic [15:0]       list_o,
    output logic              busy_o,
    output logic [NUM_PE-1:0] pend_set_o,
    output logic [ID_W-1:0]   pend_id_o,
    output logic              done_o,
    output logic              kick_o
);
    logic              busy_q, any_q, done_q, kick_q, bcast_q;
    logic [IDXW-1:0]   idx_q, src_q;
    logic [15:0]       list_q, list_nxt;
    logic [23:0]       aff_q;
    logic [ID_W-1:0]   id_q;
    logic [NUM_PE-1:0] strobe_q;
    logic              last, zero_req, accept;

    // Next working list and end-of-scan detection.
    always_comb begin
        list_nxt = list_q & ~clr_i;
        last     = (idx_q == IDXW'(NUM_PE - 1)) || (!bcast_q && list_nxt == 16'd0);
        accept   = req_valid_i && !busy_q;
        zero_req = !req_i.bcast && (req_i.tlist == 16'd0);
    end

    // Request capture and one-processor-per-clock scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            any_q    <= 1'b0;
            done_q   <= 1'b0;
            kick_q   <= 1'b0;
            bcast_q  <= 1'b0;
            idx_q    <= '0;
            src_q    <= '0;
            list_q   <= '0;
            aff_q    <= '0;
            id_q     <= '0;
            strobe_q <= '0;
        end else begin
            strobe_q <= '0;
            done_q   <= 1'b0;
            kick_q   <= 1'b0;
            if (!busy_q) begin
                if (req_valid_i) begin
                    id_q    <= req_i.intid;
                    aff_q   <= req_i.aff_hi;
                    bcast_q <= req_i.bcast;
                    list_q  <= req_i.tlist;
                    src_q   <= req_src_i;
                    idx_q   <= '0;
                    any_q   <= 1'b0;
                    if (zero_req) done_q <= 1'b1;
                    else          busy_q <= 1'b1;
                end
            end else begin
                strobe_q <= hit_i ? (NUM_PE'(1) << idx_q) : '0;
                list_q   <= list_nxt;
                any_q    <= any_q | hit_i;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    kick_q <= any_q | hit_i;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign idx_o      = idx_q;
    assign src_o      = src_q;
    assign bcast_o    = bcast_q;
    assign aff_hi_o   = aff_q;
    assign list_o     = list_q;
    assign busy_o     = busy_q;
    assign pend_set_o = strobe_q;
    assign pend_id_o  = id_q;
    assign done_o     = done_q;
    assign kick_o     = kick_q;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_q)); // R3
    AST_STROBE_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && hit_i |=> (strobe_q != '0)); // R3
    AST_KICK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_q |-> done_q); // R7
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !zero_req |=> busy_q && idx_q == '0); // R2
    AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(id_q)); // R2
    AST_BCAST_SKIPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && bcast_q && idx_q == src_q |-> !hit_i); // R4
    AST_LIST_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ((list_q & ~$past(list_q)) == 16'd0)); // R6
    AST_ZERO_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        accept && zero_req |=> done_q && !kick_q && !busy_q); // R8
endmodule

// File: rtl/sgi_dispatch.sv
// Top of the SGI dispatcher: decodes the request word, matches targets from
// the affinity table and scans processors one per clock. Table entry k sits
// at PE_AFF[32k +: 32] as {aff3, aff2, aff1, aff0}.
module sgi_dispatch
    import sgi_disp_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter logic [NUM_PE*32-1:0] PE_AFF = {32'h0000_0103, 32'h0000_0100,
                                              32'h0000_0001, 32'h0000_0000},
    localparam int IDXW = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [63:0]       req_word_i,
    input  logic [IDXW-1:0]   req_src_i,
    output logic              busy_o,
    output logic [NUM_PE-1:0] pend_set_o,
    output logic [3:0]        pend_id_o,
    output logic              done_o,
    output logic              kick_o
);
    sgi_req_t        req;
    logic [IDXW-1:0] idx, src;
    logic            bcast, hit;
    logic [23:0]     aff_hi;
    logic [15:0]     list, clr;

    // Field extraction from the raw request word.
    always_comb req = decode_req(req_word_i);

    sgi_pe_match #(.NUM_PE(NUM_PE), .PE_AFF(PE_AFF), .IDXW(IDXW)) match_i (
        .idx_i(idx), .src_i(src), .bcast_i(bcast), .aff_hi_i(aff_hi),
        .list_i(list), .hit_o(hit), .clr_o(clr)
    );

    sgi_scan_ctrl #(.NUM_PE(NUM_PE), .IDXW(IDXW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_i(req),
        .req_src_i(req_src_i), .hit_i(hit), .clr_i(clr), .idx_o(idx),
        .src_o(src), .bcast_o(bcast), .aff_hi_o(aff_hi), .list_o(list),
        .busy_o(busy_o), .pend_set_o(pend_set_o), .pend_id_o(pend_id_o),
        .done_o(done_o), .kick_o(kick_o)
    );

    AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !$past(busy_o) |-> pend_set_o == '0); // R3
endmodule

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam logic [NP*32-1:0] TAB = {32'h0000_0103, 32'h0000_0100,
                                        32'h0000_0001, 32'h0000_0000};

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
    logic [63:0] req_word = '0;
    logic [1:0] req_src = '0;
    logic busy, done, kick;
    logic [NP-1:0] pend_set;
    logic [3:0] pend_id;
    int n_chk = 0, n_bad = 0, cyc = 0;

    logic [NP-1:0] exp_strobe [0:NP+1];
    logic          exp_done   [0:NP+1];
    logic          exp_kick   [0:NP+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_dispatch #(.NUM_PE(NP), .PE_AFF(TAB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_word_i(req_word),
        .req_src_i(req_src), .busy_o(busy), .pend_set_o(pend_set),
        .pend_id_o(pend_id), .done_o(done), .kick_o(kick)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input logic [3:0] id, input logic [15:0] lst,
                                      input logic [7:0] a1, input logic [7:0] a2,
                                      input logic [7:0] a3, input logic bc);
        logic [63:0] w = '0;
        w[15:0] = lst; w[23:16] = a1; w[27:24] = id;
        w[39:32] = a2; w[40] = bc; w[55:48] = a3;
        return w;
    endfunction

    // Expected per-sample outputs, sample c taken after edge E(c) (R3-R8).
    function automatic void model(input logic [63:0] w, input int src);
        logic [15:0] lst = w[15:0];
        logic bc = w[40];
        logic any = 1'b0;
        for (int c = 0; c <= NP+1; c++) begin
            exp_strobe[c] = '0; exp_done[c] = 1'b0; exp_kick[c] = 1'b0;
        end
        if (!bc && lst == 16'd0) begin exp_done[0] = 1'b1; return; end
        for (int k = 0; k < NP; k++) begin
            logic [31:0] e = TAB[32*k +: 32];
            logic hit;
            if (bc) hit = (k != src);
            else hit = (e[31:8] == {w[55:48], w[39:32], w[23:16]}) &&
                       (e[7:0] < 8'd16) && lst[e[3:0]];
            if (hit) begin
                exp_strobe[k+1][k] = 1'b1;
                any = 1'b1;
                if (!bc) lst[e[3:0]] = 1'b0;
            end
            if (k == NP-1 || (!bc && lst == 16'd0)) begin
                exp_done[k+1] = 1'b1; exp_kick[k+1] = any; return;
            end
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one request; optionally push a second one while busy (R2).
    task automatic run(input logic [63:0] w, input int src, input bit inject);
        string ts, td;
        bit zero = !w[40] && w[15:0] == 16'd0;
        model(w, src);
        ts = inject ? "R2" : (w[40] ? "R3/R4" : "R3/R5");
        td = zero ? "R8" : "R6";
        @(negedge clk);
        req_valid = 1'b1; req_word = w; req_src = 2'(src);
        for (int c = 0; c <= NP+1; c++) begin
            @(negedge clk);
            if (c == 0 && inject) begin
                req_valid = 1'b1; req_word = mk(4'hF, 16'hFFFF, 8'd0, 8'd0, 8'd0, 1'b1);
                req_src = 2'd3;
            end else begin
                req_valid = 1'b0;
            end
            chk(pend_set == exp_strobe[c], ts, 32'(pend_set), 32'(exp_strobe[c]));
            chk(done == exp_done[c], td, 32'(done), 32'(exp_done[c]));
            chk(kick == exp_kick[c], zero ? "R8" : "R7", 32'(kick), 32'(exp_kick[c]));
            if (c == 0 && zero) chk(busy == 1'b0, "R8", 32'(busy), 32'd0);
            if (exp_done[c]) chk(pend_id == w[27:24], "R1", 32'(pend_id), 32'(w[27:24]));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(busy == 1'b0 && pend_set == '0 && done == 1'b0 && kick == 1'b0, "R9",
            {busy, pend_set, done, kick}, 32'd0);
        // Early stop on a single target (R6)
        run(mk(4'h3, 16'h0001, 8'd0, 8'd0, 8'd0, 1'b0), 1, 1'b0);
        // Two matching targets in cluster 1, list empties on the last PE (R5, R6)
        run(mk(4'h7, 16'h0009, 8'd1, 8'd0, 8'd0, 1'b0), 0, 1'b0);
        // Non-matching upper level: full scan, no kick (R5, R7)
        run(mk(4'h1, 16'hFFFF, 8'd7, 8'd0, 8'd0, 1'b0), 2, 1'b0);
        // Level 3 mismatch only (R5)
        run(mk(4'h2, 16'h0003, 8'd0, 8'd0, 8'd1, 1'b0), 0, 1'b0);
        // Broadcast from each source (R4)
        for (int s = 0; s < NP; s++) run(mk(4'(s+8), 16'h0000, 8'd0, 8'd0, 8'd0, 1'b1), s, 1'b0);
        // Zero list, targeted (R8)
        run(mk(4'hA, 16'h0000, 8'd1, 8'd0, 8'd0, 1'b0), 3, 1'b0);
        // Request while busy is ignored (R2)
        run(mk(4'h5, 16'h0002, 8'd0, 8'd0, 8'd0, 1'b0), 0, 1'b1);
        run(mk(4'h6, 16'hFFFF, 8'd0, 8'd0, 8'd0, 1'b1), 2, 1'b1);
        // Random mix
        for (int i = 0; i < 80; i++) begin
            logic [63:0] w = {$urandom, $urandom};
            w[23:16] = 8'($urandom_range(0, 1));
            w[39:32] = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0;
            w[55:48] = ($urandom_range(0, 7) == 0) ? 8'd2 : 8'd0;
            w[40]    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1) w[15:0] = w[15:0] & 16'h000B;
            run(w, int'($urandom_range(0, NP-1)), ($urandom_range(0, 5) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule